// File: doc/BRIEF.md
# Bipolar Successive-Approximation Conversion Controller

This block sequences a successive-approximation analog-to-digital conversion. A start pulse begins a conversion. The block then drives a trial code to an external DAC and reads back a comparator that reports whether the analog input is at or above the DAC voltage. It settles one bit per bit period, working from the most significant bit downward. One more bit period follows the last decision. At the end of that period the final word is latched and a single-cycle end-of-conversion pulse is raised.

In unipolar mode the trial codes and the result are straight binary. In bipolar mode the DAC is driven with offset-binary trial codes, so the sign is the first bit decided. The latched result is returned in two's complement by inverting its top bit. The word width defaults to 12 bits: 11 magnitude bits plus sign. The length of a bit period is a parameter, counted in clock cycles.

Top module: `sar_conv_ctrl`

## Requirements
- R1: While reset is held (active low, asynchronous), `busy`, `eoc`, `trial` and `result` are all zero.
- R2: A `start` sampled high while `busy` is low begins a conversion at that clock edge. From that edge `busy` is high and `trial` has only its most significant bit set.
- R3: Each bit decision takes exactly `BIT_CYC` clock cycles. The comparator is sampled at the end of each bit period. `eoc` rises exactly `(NBITS+1)*BIT_CYC` clock edges after the edge that accepted `start`.
- R4: `eoc` is high for exactly one cycle, and `busy` falls at the same edge at which `eoc` rises.
- R5: In unipolar mode (`bipolar`=0 at start), `cmp_hi`=1 keeps the trial bit and `cmp_hi`=0 clears it. The result is the straight-binary code equal to the largest trial value not above the input.
- R6: In bipolar mode (`bipolar`=1 at start), trial codes are offset binary (input v maps to code v+2^(NBITS-1)). The result is the final code with bit NBITS-1 inverted, which is v in two's complement.
- R7: A `start` pulse during a conversion is ignored, and so is any change of `bipolar` during a conversion. The running conversion's timing and result are unchanged.
- R8: `result` changes only at the edge that raises `eoc`, and otherwise holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Conversion request, sampled when idle |
| bipolar | input | 1 | Mode captured at start: 1 bipolar, 0 unipolar |
| cmp_hi | input | 1 | Comparator: 1 when the input is at or above the DAC level |
| trial | output | NBITS | Trial code driven to the external DAC |
| busy | output | 1 | Conversion in progress |
| eoc | output | 1 | One-cycle end-of-conversion pulse |
| result | output | NBITS | Latched conversion result |

## Verification
The result and `eoc` are due exactly `(NBITS+1)*BIT_CYC` edges after the edge that accepted `start`. The first trial code and `busy` are due on the edge that accepts `start`. The bench drives inputs and samples outputs on falling edges. It counts falling edges from the start edge until `eoc` is seen and compares that count with the formula. It also confirms that `eoc` is low again one cycle later.

The sweep covers every input value in both modes at a reduced 8-bit width. A second `start` with the opposite mode is injected in mid-conversion, so the timing and result checks cover R7 as well.

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl #(
  parameter int NBITS   = 12,
  parameter int BIT_CYC = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             bipolar,
  input  logic             cmp_hi,
  output logic [NBITS-1:0] trial,
  output logic             busy,
  output logic             eoc,
  output logic [NBITS-1:0] result
);
  localparam int CW = (BIT_CYC > 1) ? $clog2(BIT_CYC) : 1;
  localparam int IW = (NBITS > 1) ? $clog2(NBITS) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(BIT_CYC - 1);
  localparam logic [NBITS-1:0] ONE = NBITS'(1);

  logic [NBITS-1:0] code, kept, nxt;
  logic [CW-1:0]    cnt;
  logic [IW-1:0]    idx;
  logic             bip_q, last_per;

  assign kept  = cmp_hi ? code : (code & ~(ONE << idx));
  assign nxt   = (idx == '0) ? kept : (kept | (ONE << (idx - IW'(1))));
  assign trial = code;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      eoc      <= 1'b0;
      result   <= '0;
      code     <= '0;
      cnt      <= '0;
      idx      <= '0;
      bip_q    <= 1'b0;
      last_per <= 1'b0;
    end else begin
      eoc <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy     <= 1'b1;
          bip_q    <= bipolar;
          code     <= ONE << (NBITS - 1);
          cnt      <= '0;
          idx      <= IW'(NBITS - 1);
          last_per <= 1'b0;
        end
      end else if (cnt != CNT_LAST) begin
        cnt <= cnt + CW'(1);
      end else begin
        cnt <= '0;
        if (last_per) begin
          busy   <= 1'b0;
          eoc    <= 1'b1;
          result <= bip_q ? (code ^ (ONE << (NBITS - 1))) : code;
        end else begin
          code <= nxt;
          if (idx == '0) last_per <= 1'b1;
          else           idx <= idx - IW'(1);
        end
      end
    end
  end
endmodule

module sar_conv_ctrl_chk #(
  parameter int NBITS   = 12,
  parameter int BIT_CYC = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             eoc,
  input logic [NBITS-1:0] trial,
  input logic [NBITS-1:0] result
);
  localparam int TOTAL = (NBITS + 1) * BIT_CYC;
  int run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_cnt <= 0;
    else        run_cnt <= busy ? run_cnt + 1 : 0;
  end

  // R2
  start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && trial == (NBITS'(1) << (NBITS - 1))));
  // R4
  eoc_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eoc |=> !eoc);
  // R4
  busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> eoc);
  // R3
  conv_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eoc |-> (run_cnt == TOTAL));
  // R8
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !eoc |-> $stable(result));
endmodule

bind sar_conv_ctrl sar_conv_ctrl_chk #(.NBITS(NBITS), .BIT_CYC(BIT_CYC)) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
  .eoc(eoc), .trial(trial), .result(result));

// File: tb/sar_conv_ctrl_tb.sv
`timescale 1ns/1ps
module sar_conv_ctrl_tb_top;
  localparam int N = 8;
  localparam int B = 3;
  localparam int HALF = 1 << (N - 1);
  localparam int TOTAL = (N + 1) * B;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, bipolar = 1'b0;
  logic cmp_hi, busy, eoc;
  logic [N-1:0] trial, result;
  int vin = 0;
  bit mode_b = 1'b0;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  assign cmp_hi = mode_b ? ((vin + HALF) >= int'(trial)) : (vin >= int'(trial));

  sar_conv_ctrl #(.NBITS(N), .BIT_CYC(B)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .bipolar(bipolar), .cmp_hi(cmp_hi),
    .trial(trial), .busy(busy), .eoc(eoc), .result(result));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic convert(input bit m, input int v);
    int n;
    int expv;
    @(negedge clk);
    mode_b = m; vin = v; bipolar = m; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy && trial == N'(HALF), "R2", int'(trial), HALF);
    n = 0;
    while (!eoc && n < TOTAL + 5) begin
      @(negedge clk);
      n++;
      if (n == 5) begin start = 1'b1; bipolar = ~m; end  // R7 stray start
      if (n == 6) start = 1'b0;
    end
    check(n == TOTAL, "R3/R7 length", n, TOTAL);
    check(!busy, "R4 busy", int'(busy), 0);
    expv = m ? (v & ((1 << N) - 1)) : v;
    check(int'(result) == expv, m ? "R6/R7 bipolar" : "R5/R7 unipolar", int'(result), expv);
    @(negedge clk);
    check(!eoc, "R4 pulse", int'(eoc), 0);
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #20;
    check(!busy && !eoc && trial == '0 && result == '0, "R1", int'(result), 0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int v = 0; v < (1 << N); v++) convert(1'b0, v);
    for (int v = -HALF; v < HALF; v++) convert(1'b1, v);
    vin = 0; mode_b = 1'b0;
    for (int k = 0; k < 2 * TOTAL; k++) begin
      @(negedge clk);
      vin = k % (1 << N);
      check(result == N'(HALF - 1), "R8 hold", int'(result), HALF - 1);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule